// File: doc/BRIEF.md
# Write-Back Write-Allocate Data Cache Controller

This block sits behind the memory stage of a pipelined core and serves its loads and stores from a small direct-mapped line store. It keeps a valid bit, a tag and a dirty bit for every line. A store that hits changes only the local copy and marks the line dirty. A miss of either kind first fetches the whole line from the next level. A store that misses is merged into that fetched line. The next level sees a write only when a dirty line has to make room for a new one.

The core presents one request at a time and reads a single response. While a miss is being served, the controller raises its stall output, so the pipeline holds the instruction in the memory stage. Behind the controller is a plain line-wide request/response port. A request is held until the next level answers it with a one-cycle response. For a read, that response carries the line data.

Top module: `wbwa_cache_ctrl`

## Requirements
- R1: A store that hits writes its enabled bytes into the resident line and sets that line's dirty bit. It raises no request on the next-level port.
- R2: A load or store that hits answers in the same cycle: resp_valid is 1 and stall is 0. For a load, resp_rdata is the stored word; for a store, it is the word after the bytes are merged.
- R3: Request addresses are word addresses. Bits [1:0] select the word in a 4-word line, bits [3:2] select the set, and the remaining upper bits form the tag. A load or store miss issues a line read (mem_req_write = 0) at line address req_addr[ADDR_W-1:2], and never writes the requested word downstream.
- R4: Once a refill returns, the store is merged into the fetched line. Byte-enable bit i selects bits [8i+7:8i]. The other bytes keep their fetched values. The line is installed dirty, and resp_rdata carries the merged word.
- R5: stall is 1 from the cycle the miss is seen until the cycle in which the refill response arrives. In the following update cycle, stall is 0 and resp_valid is 1.
- R6: A dirty victim is written back before the refill. The write uses line address {victim tag, set} and carries the full victim line. A clean or empty victim goes straight to the refill.
- R7: A line refilled for a load is installed clean, so evicting it later causes no write-back.
- R8: Any number of stores to one line cost at most one refill and one later write-back.
- R9: The request inputs are ignored whenever the controller is not idle. A miss completes with the request captured when the miss was seen.
- R10: After reset every line is invalid, and stall, resp_valid and mem_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present from the memory stage |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| stall | output | 1 | Hold the memory stage |
| resp_valid | output | 1 | Access completes this cycle |
| resp_rdata | output | 32 | Load word, or merged store word |
| mem_req_valid | output | 1 | Next-level request pending |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | ADDR_W-2 | Line address |
| mem_req_wdata | output | 128 | Write-back line data |
| mem_resp_valid | input | 1 | One-cycle completion from the next level |
| mem_resp_data | input | 128 | Refill line data |

## Verification
Some rules are checked by the assertions on every cycle. A store hit is never followed by downstream traffic. A miss raises a next-level request in the following cycle. A falling stall always coincides with a response. A write-back is only ever issued for a valid dirty line. Every line-store update leaves the dirty bit that was requested. Other behaviour only the scenarios can show. These are the data contents: byte merging against fetched values, write-back data landing in the next level and being read back, clean installation after load refills, the count of refills and write-backs across a burst of stores, and the fact that request inputs changed during a miss have no effect.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int CC_WORD_W = 32;
    localparam int CC_BYTES  = CC_WORD_W / 8;

    typedef logic [CC_WORD_W-1:0] cc_word_t;
    typedef logic [CC_BYTES-1:0]  cc_be_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_REFILL    = 2'd2,
        ST_UPDATE    = 2'd3
    } cc_state_e;

    typedef struct packed {
        logic     write;
        cc_word_t wdata;
        cc_be_t   be;
    } cc_store_t;

    function automatic cc_word_t cc_merge_word(cc_word_t old_w, cc_word_t new_w, cc_be_t be);
        cc_word_t r;
        r = old_w;
        for (int b = 0; b < CC_BYTES; b++) begin
            if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cc_line_store.sv
module cc_line_store #(
    parameter int NUM_SETS = 4,
    parameter int TAG_W    = 10,
    parameter int LINE_W   = 128,
    localparam int IDX_W   = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_dirty,
    input  logic [LINE_W-1:0] wr_line
);
    logic [NUM_SETS-1:0] valid_q;
    logic [NUM_SETS-1:0] dirty_q;
    logic [TAG_W-1:0]    tag_q  [NUM_SETS];
    logic [LINE_W-1:0]   line_q [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            line_q[wr_idx] <= wr_line;
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_dirty = dirty_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_line  = line_q[rd_idx];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid_q[$past(wr_idx)] && (dirty_q[$past(wr_idx)] == $past(wr_dirty)))); // R4

endmodule

// File: rtl/cc_line_merge.sv
module cc_line_merge
    import cc_pkg::*;
#(
    parameter int WORDS  = 4,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int LINE_W = WORDS * CC_WORD_W
) (
    input  logic [LINE_W-1:0] line_in,
    input  logic [WSEL_W-1:0] word_sel,
    input  logic              merge_en,
    input  cc_word_t          wdata,
    input  cc_be_t            be,
    output logic [LINE_W-1:0] line_out,
    output cc_word_t          word_out
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign line_out[w*CC_WORD_W +: CC_WORD_W] =
            (merge_en && (word_sel == WSEL_W'(w)))
                ? cc_merge_word(line_in[w*CC_WORD_W +: CC_WORD_W], wdata, be)
                : line_in[w*CC_WORD_W +: CC_WORD_W];
    end

    assign word_out = line_out[word_sel*CC_WORD_W +: CC_WORD_W];

endmodule

// File: rtl/cc_miss_fsm.sv
module cc_miss_fsm
    import cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_miss,
    input  logic      victim_dirty,
    input  logic      mem_resp_valid,
    output cc_state_e state
);
    cc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_miss) state_d = victim_dirty ? ST_WRITEBACK : ST_REFILL;
            ST_WRITEBACK: if (mem_resp_valid) state_d = ST_REFILL;
            ST_REFILL:    if (mem_resp_valid) state_d = ST_UPDATE;
            ST_UPDATE:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;

    AST_UPDATE_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REFILL && mem_resp_valid) |=> (state_q == ST_UPDATE)); // R5

endmodule

// File: rtl/wbwa_cache_ctrl.sv
module wbwa_cache_ctrl
    import cc_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int WORDS    = 4,
    parameter int NUM_SETS = 4,
    localparam int WSEL_W  = $clog2(WORDS),
    localparam int IDX_W   = $clog2(NUM_SETS),
    localparam int TAG_W   = ADDR_W - WSEL_W - IDX_W,
    localparam int LADDR_W = ADDR_W - WSEL_W,
    localparam int LINE_W  = WORDS * CC_WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [3:0]         req_be,
    output logic               stall,
    output logic               resp_valid,
    output logic [31:0]        resp_rdata,
    output logic               mem_req_valid,
    output logic               mem_req_write,
    output logic [LADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0]  mem_req_wdata,
    input  logic               mem_resp_valid,
    input  logic [LINE_W-1:0]  mem_resp_data
);
    cc_state_e state;

    logic [WSEL_W-1:0] req_wsel;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    assign req_wsel = req_addr[WSEL_W-1:0];
    assign req_idx  = req_addr[WSEL_W +: IDX_W];
    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];

    logic [ADDR_W-1:0] cap_addr_q;
    cc_store_t         cap_q;
    logic [LINE_W-1:0] fill_q;
    logic [WSEL_W-1:0] cap_wsel;
    logic [IDX_W-1:0]  cap_idx;
    logic [TAG_W-1:0]  cap_tag;
    assign cap_wsel = cap_addr_q[WSEL_W-1:0];
    assign cap_idx  = cap_addr_q[WSEL_W +: IDX_W];
    assign cap_tag  = cap_addr_q[ADDR_W-1 -: TAG_W];

    logic              is_idle, in_update;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;
    logic              hit, accept, start_miss, hit_write;

    assign is_idle    = (state == ST_IDLE);
    assign in_update  = (state == ST_UPDATE);
    assign rd_idx     = is_idle ? req_idx : cap_idx;
    assign hit        = rd_valid && (rd_tag == req_tag);
    assign accept     = is_idle && req_valid;
    assign start_miss = accept && !hit;
    assign hit_write  = accept && hit && req_write;

    logic              wr_en, wr_dirty;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [LINE_W-1:0] merged_line;
    cc_word_t          merged_word;

    logic [LINE_W-1:0] mg_line_in;
    logic [WSEL_W-1:0] mg_sel;
    logic              mg_en;
    cc_word_t          mg_wdata;
    cc_be_t            mg_be;

    always_comb begin
        if (in_update) begin
            mg_line_in = fill_q;
            mg_sel     = cap_wsel;
            mg_en      = cap_q.write;
            mg_wdata   = cap_q.wdata;
            mg_be      = cap_q.be;
        end else begin
            mg_line_in = rd_line;
            mg_sel     = req_wsel;
            mg_en      = req_write;
            mg_wdata   = req_wdata;
            mg_be      = req_be;
        end
    end

    cc_line_merge #(.WORDS(WORDS)) merge_i (
        .line_in  (mg_line_in),
        .word_sel (mg_sel),
        .merge_en (mg_en),
        .wdata    (mg_wdata),
        .be       (mg_be),
        .line_out (merged_line),
        .word_out (merged_word)
    );

    assign wr_en    = hit_write || in_update;
    assign wr_idx   = in_update ? cap_idx : req_idx;
    assign wr_tag   = in_update ? cap_tag : req_tag;
    assign wr_dirty = in_update ? cap_q.write : 1'b1;

    cc_line_store #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) store_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .rd_line  (rd_line),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_dirty (wr_dirty),
        .wr_line  (merged_line)
    );

    cc_miss_fsm fsm_i (
        .clk            (clk),
        .rst            (rst),
        .start_miss     (start_miss),
        .victim_dirty   (rd_valid && rd_dirty),
        .mem_resp_valid (mem_resp_valid),
        .state          (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_addr_q <= '0;
            cap_q      <= '0;
            fill_q     <= '0;
        end else begin
            if (start_miss) begin
                cap_addr_q  <= req_addr;
                cap_q.write <= req_write;
                cap_q.wdata <= req_wdata;
                cap_q.be    <= req_be;
            end
            if (state == ST_REFILL && mem_resp_valid) fill_q <= mem_resp_data;
        end
    end

    assign mem_req_valid = (state == ST_WRITEBACK) || (state == ST_REFILL);
    assign mem_req_write = (state == ST_WRITEBACK);
    assign mem_req_addr  = (state == ST_WRITEBACK) ? {rd_tag, cap_idx} : {cap_tag, cap_idx};
    assign mem_req_wdata = rd_line;

    assign stall      = start_miss || mem_req_valid;
    assign resp_valid = (accept && hit) || in_update;
    assign resp_rdata = merged_word;

    AST_STORE_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        hit_write |=> !mem_req_valid); // R1
    AST_NO_STALL_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !stall) |-> resp_valid); // R2
    AST_MISS_ISSUES_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |=> mem_req_valid); // R3
    AST_STALL_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> resp_valid); // R5
    AST_WB_DIRTY_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (rd_valid && rd_dirty)); // R6
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !wr_en); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req_valid && !resp_valid)); // R10

endmodule

// File: tb/wbwa_cache_ctrl_tb_top.sv
module wbwa_cache_ctrl_tb_top;
    localparam int AW   = 14;
    localparam int LAW  = 12;
    localparam int LW   = 128;
    localparam int LAT  = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [31:0]    req_wdata = '0;
    logic [3:0]     req_be = '0;
    logic           stall, resp_valid;
    logic [31:0]    resp_rdata;
    logic           mem_req_valid, mem_req_write;
    logic [LAW-1:0] mem_req_addr;
    logic [LW-1:0]  mem_req_wdata;
    logic           mem_resp_valid = 1'b0;
    logic [LW-1:0]  mem_resp_data = '0;

    wbwa_cache_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .stall(stall), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int n_wb = 0;
    int n_fill = 0;

    logic          m_valid [4];
    logic          m_dirty [4];
    logic [9:0]    m_tag   [4];
    logic [LW-1:0] m_line  [4];
    logic [LW-1:0] mem [int];

    function automatic logic [LW-1:0] mem_line(int la);
        logic [LW-1:0] l;
        if (mem.exists(la)) return mem[la];
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = 32'hC0DE0000 ^ (la << 4) ^ w;
        return l;
    endfunction

    function automatic logic [31:0] bmerge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string rq, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic expect_cycle(input string rq, input logic e_stall, input logic e_resp,
                                input logic [31:0] e_rdata, input logic e_mreq, input logic e_mwr,
                                input logic [LAW-1:0] e_maddr, input logic [LW-1:0] e_mwd);
        chk(rq, "stall", LW'(stall), LW'(e_stall));
        chk(rq, "resp_valid", LW'(resp_valid), LW'(e_resp));
        if (e_resp) chk(rq, "resp_rdata", LW'(resp_rdata), LW'(e_rdata));
        chk(rq, "mem_req_valid", LW'(mem_req_valid), LW'(e_mreq));
        if (e_mreq) begin
            chk(rq, "mem_req_write", LW'(mem_req_write), LW'(e_mwr));
            chk(rq, "mem_req_addr", LW'(mem_req_addr), LW'(e_maddr));
            if (e_mwr) chk(rq, "mem_req_wdata", mem_req_wdata, e_mwd);
        end
    endtask

    task automatic idle_cycle(input string rq);
        @(negedge clk);
        req_valid = 1'b0;
        mem_resp_valid = 1'b0;
        #5;
        expect_cycle(rq, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic junk(input logic w, input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        req_valid = 1'b1;
        req_write = ~w;
        req_addr  = ~a;
        req_wdata = ~d;
        req_be    = ~be;
    endtask

    task automatic do_req(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [3:0] be, input string rq);
        int idx = int'(a[3:2]);
        int ws  = int'(a[1:0]);
        logic [9:0] tg = a[13:4];
        int la = int'(a[13:2]);
        logic hit;
        logic [31:0] nw;
        logic [LW-1:0] fl;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        mem_resp_valid = 1'b0;
        hit = m_valid[idx] && (m_tag[idx] == tg);
        #5;
        if (hit) begin
            nw = w ? bmerge(m_line[idx][ws*32 +: 32], d, be) : m_line[idx][ws*32 +: 32];
            expect_cycle(rq, 1'b0, 1'b1, nw, 1'b0, 1'b0, '0, '0);
            if (w) begin
                m_line[idx][ws*32 +: 32] = nw;
                m_dirty[idx] = 1'b1;
            end
            return;
        end
        expect_cycle(rq, 1'b1, 1'b0, '0, 1'b0, 1'b0, '0, '0);
        if (m_valid[idx] && m_dirty[idx]) begin
            for (int k = 0; k <= LAT; k++) begin
                @(negedge clk);
                junk(w, a, d, be);
                mem_resp_valid = (k == LAT);
                #5;
                expect_cycle("R6", 1'b1, 1'b0, '0, 1'b1, 1'b1, {m_tag[idx], 2'(idx)}, m_line[idx]);
            end
            mem[int'({m_tag[idx], 2'(idx)})] = m_line[idx];
            n_wb++;
        end
        fl = mem_line(la);
        for (int k = 0; k <= LAT; k++) begin
            @(negedge clk);
            junk(w, a, d, be);
            mem_resp_valid = (k == LAT);
            mem_resp_data = fl;
            #5;
            expect_cycle("R3", 1'b1, 1'b0, '0, 1'b1, 1'b0, LAW'(la), '0);
        end
        n_fill++;
        @(negedge clk);
        junk(w, a, d, be);
        mem_resp_valid = 1'b0;
        mem_resp_data = '0;
        nw = w ? bmerge(fl[ws*32 +: 32], d, be) : fl[ws*32 +: 32];
        #5;
        expect_cycle(w ? "R4 R9" : "R7 R9", 1'b0, 1'b1, nw, 1'b0, 1'b0, '0, '0);
        fl[ws*32 +: 32] = nw;
        m_line[idx] = fl;
        m_tag[idx] = tg;
        m_valid[idx] = 1'b1;
        m_dirty[idx] = w;
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int wb0, fill0;
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0; m_line[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: quiet outputs after reset, first access misses
        idle_cycle("R10");
        do_req(1'b0, 14'h0100, '0, 4'h0, "R10");
        // R1 R2: store hit then load hit
        wb0 = n_wb;
        do_req(1'b1, 14'h0101, 32'h11223344, 4'hF, "R1");
        idle_cycle("R1");
        do_req(1'b0, 14'h0101, '0, 4'h0, "R2");
        chk("R1", "no write-back on store hit", LW'(n_wb), LW'(wb0));
        // R4: store miss with partial byte enables
        do_req(1'b1, 14'h0215, 32'hAABBCCDD, 4'b0101, "R4");
        do_req(1'b0, 14'h0215, '0, 4'h0, "R4");
        // R6: dirty victim written back before refill, then re-read from next level
        wb0 = n_wb;
        do_req(1'b0, 14'h0615, '0, 4'h0, "R6");
        chk("R6", "write-back count", LW'(n_wb), LW'(wb0 + 1));
        // R7: victim refilled by a load is clean
        wb0 = n_wb;
        do_req(1'b0, 14'h0215, '0, 4'h0, "R7");
        chk("R7", "clean victim write-back count", LW'(n_wb), LW'(wb0));
        // R6: set 0 dirty from the store hit
        do_req(1'b0, 14'h0500, '0, 4'h0, "R6");
        do_req(1'b0, 14'h0101, '0, 4'h0, "R6");
        // R8: burst of stores to one line
        wb0 = n_wb; fill0 = n_fill;
        for (int i = 0; i < 6; i++)
            do_req(1'b1, 14'h0028 | 14'(i % 4), 32'h5A000000 + 32'(i), 4'hF, "R8");
        chk("R8", "refills for store burst", LW'(n_fill), LW'(fill0 + 1));
        chk("R8", "write-backs before eviction", LW'(n_wb), LW'(wb0));
        do_req(1'b0, 14'h0828, '0, 4'h0, "R8");
        chk("R8", "write-backs after eviction", LW'(n_wb), LW'(wb0 + 1));
        do_req(1'b0, 14'h0029, '0, 4'h0, "R8");
        // R9: stall-time inputs had no effect on what was written
        do_req(1'b0, 14'h0216, '0, 4'h0, "R9");
        idle_cycle("R9");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule